// File: doc/BRIEF.md
# Instruction Fetch and Redirect Controller

This block is the front end of a five-stage, in-order, 8-bit pipeline. It keeps an 8-bit program counter, reads each 16-bit instruction as two bytes from instruction memory, and presents the word to decode through a valid/ready stage register. Decode sends back flags on each word it accepts. These flags mark a control transfer or a halt. The later stages report when a transfer resolves, whether it is a relative jump, a taken branch or a branch not taken.

The block also keeps the performance counters for the pipeline: active cycles, data stalls, control stalls, and one counter per instruction class, fed by a retire strobe from execute. After a halt has been taken, a done flag rises once the pipeline has drained.

Back-pressure rules: the word on `inst_data` is transferred on a rising edge where `inst_valid` and `inst_ready` are both high. While `inst_valid` is high and `inst_ready` is low, the word and the program counter stay frozen, and that cycle counts as a data stall. `dec_xfer` and `dec_halt` are looked at only on a transfer edge.

Top module: `ifetch_steer`

## Requirements
- R1: While reset is held, `inst_valid` and `done` are low, `imem_hi_addr` is 0, and every counter reads 0.
- R2: A fetch presents `{mem[pc], mem[pc+1]}` (high byte at the lower address) and advances pc by 2. All address arithmetic wraps modulo 256, so `imem_lo_addr` is always `imem_hi_addr + 1` modulo 256.
- R3: Each edge with `inst_valid` high and `inst_ready` low keeps `inst_data` and pc unchanged and adds 1 to `data_stall_count`.
- R4: When a word is taken with `dec_xfer` high and `dec_halt` low, the following word is dropped and `inst_valid` goes low. No fetch happens until a resolve arrives, and `ctrl_stall_count` rises by 2.
- R5: A resolve with `res_jump` high sets pc to pc + 2*`res_value` modulo 256. Here pc is the address of the word after the transfer instruction.
- R6: A resolve with `res_jump` low and `res_taken` high loads pc with `res_value`. With `res_taken` low, pc keeps the address of the word after the branch.
- R7: A `res_valid` pulse while no transfer is pending has no effect.
- R8: Once a word is taken with `dec_halt` high, no further fetch happens and `inst_valid` stays low until reset.
- R9: `done` rises after the first edge, following a halt, at which no activity is seen, and it then stays high. It never rises before a halt.
- R10: `cycle_count` rises by 1 on each edge where a fetch happens, `inst_valid` is high, or `back_busy` is high. It is unchanged on all other edges.
- R11: `retire_valid` with `retire_class` from 0 to 6 adds 1 to `class_count[retire_class]`. The class codes are 0 arithmetic, 1 logical, 2 shift, 3 memory, 4 load-immediate, 5 control, 6 halt. Code 7 changes no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_hi_addr | output | 8 | Address of the high instruction byte (pc) |
| imem_hi_data | input | 8 | Byte read at `imem_hi_addr`, same cycle |
| imem_lo_addr | output | 8 | Address of the low instruction byte (pc+1) |
| imem_lo_data | input | 8 | Byte read at `imem_lo_addr`, same cycle |
| inst_data | output | 16 | Instruction word toward decode |
| inst_valid | output | 1 | `inst_data` holds a word |
| inst_ready | input | 1 | Decode takes the word |
| dec_xfer | input | 1 | Taken word is a jump or branch |
| dec_halt | input | 1 | Taken word is a halt |
| res_valid | input | 1 | Pending transfer resolves this cycle |
| res_jump | input | 1 | Resolve is a relative jump |
| res_taken | input | 1 | Branch is taken |
| res_value | input | 8 | Jump offset or branch target |
| back_busy | input | 1 | Execute, memory or write-back did work |
| retire_valid | input | 1 | An instruction completed execute |
| retire_class | input | 3 | Class code of the retiring instruction |
| cycle_count | output | 16 | Active-cycle counter |
| data_stall_count | output | 16 | Data-stall counter |
| ctrl_stall_count | output | 16 | Control-stall counter |
| class_count | output | 7x16 | Per-class retire counters, index = class code |
| done | output | 1 | Pipeline drained after a halt |

## Verification
The hardest cases to reach from the ports are those where pc arithmetic wraps past 255. This happens for a branch to the last byte, where the low byte comes from address 0, and for a jump whose doubled offset overflows. The bench reaches them by taking chosen words as transfers and resolving them with target 0xFF and jump offset 0xF0. It also sends a resolve pulse while decode is stalled and no transfer is pending, to show that pc does not move. A halt followed by a busy tail from the back end then exercises the point where done rises.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int NCLS = 7;
  localparam int CLW  = 3;
  typedef enum logic [CLW-1:0] {
    CL_ARITH = 3'd0, CL_LOGIC = 3'd1, CL_SHIFT = 3'd2, CL_MEM = 3'd3,
    CL_LDI = 3'd4, CL_CTRL = 3'd5, CL_HALT = 3'd6, CL_NONE = 3'd7
  } iclass_e;
endpackage

// File: rtl/ifetch_pc_unit.sv
module ifetch_pc_unit #(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   hi_addr,
  output logic [AW-1:0]   lo_addr,
  input  logic [BW-1:0]   hi_data,
  input  logic [BW-1:0]   lo_data,
  output logic [2*BW-1:0] word,
  output logic            word_valid,
  input  logic            word_ready,
  input  logic            is_xfer,
  input  logic            is_halt,
  input  logic            rsv_valid,
  input  logic            rsv_jump,
  input  logic            rsv_taken,
  input  logic [AW-1:0]   rsv_value,
  output logic            fetch_fire,
  output logic            take_xfer,
  output logic            halted
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0]   pc;
  logic [2*BW-1:0] ibuf;
  logic            ibuf_v;
  logic            waiting;
  logic            accept, take_halt, room, rsv_apply;

  assign accept     = ibuf_v & word_ready;
  assign take_halt  = accept & is_halt;
  assign take_xfer  = accept & is_xfer & ~is_halt;
  assign room       = ~ibuf_v | accept;
  assign fetch_fire = ~halted & ~waiting & room & ~take_halt & ~take_xfer;
  assign rsv_apply  = waiting & rsv_valid;

  assign hi_addr    = pc;
  assign lo_addr    = pc + AW'(1);
  assign word       = ibuf;
  assign word_valid = ibuf_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      ibuf    <= '0;
      ibuf_v  <= 1'b0;
      waiting <= 1'b0;
      halted  <= 1'b0;
    end else begin
      if (fetch_fire) begin
        ibuf   <= {hi_data, lo_data};
        ibuf_v <= 1'b1;
        pc     <= pc + STEP;
      end else if (accept) begin
        ibuf_v <= 1'b0;
      end
      if (take_halt) halted <= 1'b1;
      if (take_xfer) begin
        waiting <= 1'b1;
      end else if (rsv_apply) begin
        waiting <= 1'b0;
        if (rsv_jump)       pc <= pc + (rsv_value << 1);
        else if (rsv_taken) pc <= rsv_value;
      end
    end
  end
endmodule

// File: rtl/ifetch_perf.sv
module ifetch_perf #(
  parameter int CW   = 16,
  parameter int NCLS = 7,
  parameter int CLW  = 3,
  parameter int PEN  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      act,
  input  logic                      halted,
  input  logic                      dstall_inc,
  input  logic                      cstall_inc,
  input  logic                      retire_valid,
  input  logic [CLW-1:0]            retire_class,
  output logic [CW-1:0]             cycle_count,
  output logic [CW-1:0]             data_stall_count,
  output logic [CW-1:0]             ctrl_stall_count,
  output logic [NCLS-1:0][CW-1:0]   class_count,
  output logic                      done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle_count      <= '0;
      data_stall_count <= '0;
      ctrl_stall_count <= '0;
      done             <= 1'b0;
    end else begin
      if (act)        cycle_count      <= cycle_count + CW'(1);
      if (dstall_inc) data_stall_count <= data_stall_count + CW'(1);
      if (cstall_inc) ctrl_stall_count <= ctrl_stall_count + CW'(PEN);
      if (halted && !act) done <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    always_ff @(posedge clk) begin
      if (!rst_n)
        class_count[g] <= '0;
      else if (retire_valid && retire_class == CLW'(g))
        class_count[g] <= class_count[g] + CW'(1);
    end
  end
endmodule

// File: rtl/ifetch_steer.sv
module ifetch_steer #(
  parameter int AW  = 8,
  parameter int BW  = 8,
  parameter int CW  = 16,
  parameter int PEN = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  output logic [AW-1:0]                       imem_hi_addr,
  input  logic [BW-1:0]                       imem_hi_data,
  output logic [AW-1:0]                       imem_lo_addr,
  input  logic [BW-1:0]                       imem_lo_data,
  output logic [2*BW-1:0]                     inst_data,
  output logic                                inst_valid,
  input  logic                                inst_ready,
  input  logic                                dec_xfer,
  input  logic                                dec_halt,
  input  logic                                res_valid,
  input  logic                                res_jump,
  input  logic                                res_taken,
  input  logic [AW-1:0]                       res_value,
  input  logic                                back_busy,
  input  logic                                retire_valid,
  input  logic [ifetch_pkg::CLW-1:0]          retire_class,
  output logic [CW-1:0]                       cycle_count,
  output logic [CW-1:0]                       data_stall_count,
  output logic [CW-1:0]                       ctrl_stall_count,
  output logic [ifetch_pkg::NCLS-1:0][CW-1:0] class_count,
  output logic                                done
);
  logic fetch_fire, take_xfer, halted, act, dstall_inc;

  ifetch_pc_unit #(.AW(AW), .BW(BW)) i_pc (
    .clk(clk), .rst_n(rst_n),
    .hi_addr(imem_hi_addr), .lo_addr(imem_lo_addr),
    .hi_data(imem_hi_data), .lo_data(imem_lo_data),
    .word(inst_data), .word_valid(inst_valid), .word_ready(inst_ready),
    .is_xfer(dec_xfer), .is_halt(dec_halt),
    .rsv_valid(res_valid), .rsv_jump(res_jump), .rsv_taken(res_taken),
    .rsv_value(res_value),
    .fetch_fire(fetch_fire), .take_xfer(take_xfer), .halted(halted)
  );

  assign act        = fetch_fire | inst_valid | back_busy;
  assign dstall_inc = inst_valid & ~inst_ready;

  ifetch_perf #(.CW(CW), .NCLS(ifetch_pkg::NCLS), .CLW(ifetch_pkg::CLW), .PEN(PEN)) i_perf (
    .clk(clk), .rst_n(rst_n), .act(act), .halted(halted),
    .dstall_inc(dstall_inc), .cstall_inc(take_xfer),
    .retire_valid(retire_valid), .retire_class(retire_class),
    .cycle_count(cycle_count), .data_stall_count(data_stall_count),
    .ctrl_stall_count(ctrl_stall_count), .class_count(class_count),
    .done(done)
  );
endmodule

// File: rtl/ifetch_steer_chk.sv
module ifetch_steer_chk #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int CW = 16
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [AW-1:0]                       imem_hi_addr,
  input logic [AW-1:0]                       imem_lo_addr,
  input logic [2*BW-1:0]                     inst_data,
  input logic                                inst_valid,
  input logic                                inst_ready,
  input logic                                dec_xfer,
  input logic                                dec_halt,
  input logic                                retire_valid,
  input logic [ifetch_pkg::CLW-1:0]          retire_class,
  input logic [CW-1:0]                       data_stall_count,
  input logic [CW-1:0]                       ctrl_stall_count,
  input logic [ifetch_pkg::NCLS-1:0][CW-1:0] class_count,
  input logic                                done
);
  a_r2_lo_follows_hi: assert property (@(posedge clk) disable iff (!rst_n)
    imem_lo_addr == imem_hi_addr + AW'(1));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && inst_ready && !dec_xfer && !dec_halt |=> imem_hi_addr == $past(imem_hi_addr) + AW'(2));

  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && !inst_ready |=> inst_valid && $stable(inst_data) && $stable(imem_hi_addr));

  a_r3_stall_count: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && !inst_ready |=> data_stall_count == $past(data_stall_count) + CW'(1));

  a_r4_xfer_drop: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && inst_ready && dec_xfer && !dec_halt |=>
      !inst_valid && ctrl_stall_count == $past(ctrl_stall_count) + CW'(2));

  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !inst_valid);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r11_code7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && retire_class == 3'd7 |=> $stable(class_count));
endmodule

bind ifetch_steer ifetch_steer_chk #(.AW(AW), .BW(BW), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .imem_hi_addr(imem_hi_addr), .imem_lo_addr(imem_lo_addr),
  .inst_data(inst_data), .inst_valid(inst_valid), .inst_ready(inst_ready),
  .dec_xfer(dec_xfer), .dec_halt(dec_halt),
  .retire_valid(retire_valid), .retire_class(retire_class),
  .data_stall_count(data_stall_count), .ctrl_stall_count(ctrl_stall_count),
  .class_count(class_count), .done(done)
);

// File: tb/test_ifetch_steer.sv
module test_ifetch_steer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] imem_hi_addr, imem_lo_addr, imem_hi_data, imem_lo_data;
  logic [15:0] inst_data;
  logic inst_valid;
  logic inst_ready = 0, dec_xfer = 0, dec_halt = 0;
  logic res_valid = 0, res_jump = 0, res_taken = 0;
  logic [7:0] res_value = 0;
  logic back_busy = 0, retire_valid = 0;
  logic [2:0] retire_class = 0;
  logic [15:0] cycle_count, data_stall_count, ctrl_stall_count;
  logic [6:0][15:0] class_count;
  logic done;

  logic [7:0] mem [256];
  int checks = 0, fails = 0;
  int exp_q[$];
  int exp_ds = 0, exp_cs = 0;
  int exp_cls[8];
  int snap;

  always #4 clk = ~clk;

  assign imem_hi_data = mem[imem_hi_addr];
  assign imem_lo_data = mem[imem_lo_addr];

  ifetch_steer i_ifetch_steer (
    .clk(clk), .rst_n(rst_n),
    .imem_hi_addr(imem_hi_addr), .imem_hi_data(imem_hi_data),
    .imem_lo_addr(imem_lo_addr), .imem_lo_data(imem_lo_data),
    .inst_data(inst_data), .inst_valid(inst_valid), .inst_ready(inst_ready),
    .dec_xfer(dec_xfer), .dec_halt(dec_halt),
    .res_valid(res_valid), .res_jump(res_jump), .res_taken(res_taken),
    .res_value(res_value), .back_busy(back_busy),
    .retire_valid(retire_valid), .retire_class(retire_class),
    .cycle_count(cycle_count), .data_stall_count(data_stall_count),
    .ctrl_stall_count(ctrl_stall_count), .class_count(class_count),
    .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int word_at(input int a);
    return {mem[a & 255], mem[(a + 1) & 255]};
  endfunction

  // driver side: expected words go into the scoreboard queue
  task automatic push(input int a);
    exp_q.push_back(word_at(a));
  endtask

  task automatic take(input logic xf, input logic ht);
    inst_ready = 1; dec_xfer = xf; dec_halt = ht;
    do @(negedge clk); while (!inst_valid);
    @(posedge clk); #2;
    inst_ready = 0; dec_xfer = 0; dec_halt = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (inst_valid) exp_ds++;   // R3 stall expectation
      @(posedge clk);
    end
    #2;
  endtask

  task automatic resolve(input logic jmp, input logic tk, input logic [7:0] v);
    res_valid = 1; res_jump = jmp; res_taken = tk; res_value = v;
    idle(1);
    res_valid = 0; res_jump = 0; res_taken = 0; res_value = 0;
  endtask

  // monitor: pops and compares on every transfer toward decode (R2)
  always @(negedge clk) begin
    if (rst_n && inst_valid && inst_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected word actual=%0h expected=none", inst_data);
      end else begin
        chk("R2 fetched word", int'(inst_data), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 8; i++) exp_cls[i] = 0;
    repeat (3) @(posedge clk); #2;
    chk("R1 valid in reset", int'(inst_valid), 0);
    chk("R1 pc in reset", int'(imem_hi_addr), 0);
    chk("R1 cycles in reset", int'(cycle_count), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 stalls in reset", int'(data_stall_count), 0);
    rst_n = 1;

    push(0); take(0, 0);
    push(2); take(0, 0);
    snap = int'(cycle_count);
    push(4); take(0, 0);
    push(6); take(0, 0);
    chk("R10 steady cycles", int'(cycle_count), snap + 2);

    // back-pressure with an ignored resolve (R3, R7)
    idle(2);
    resolve(1'b1, 1'b0, 8'h40);
    chk("R3 pc held", int'(imem_hi_addr), 10);
    chk("R7 ignored resolve", int'(imem_hi_addr), 10);
    chk("R3 word held", int'(inst_data), word_at(8));
    chk("R3 stall count", int'(data_stall_count), exp_ds);

    // jump (R4, R5)
    push(8); take(0, 0);
    push(10); take(1, 0); exp_cs += 2;
    chk("R4 valid dropped", int'(inst_valid), 0);
    chk("R4 ctrl stalls", int'(ctrl_stall_count), exp_cs);
    snap = int'(cycle_count);
    idle(2);
    chk("R4 no fetch while pending", int'(imem_hi_addr), 12);
    chk("R10 idle cycles", int'(cycle_count), snap);
    resolve(1'b1, 1'b0, 8'h10);
    chk("R5 jump target", int'(imem_hi_addr), 'h2C);
    push('h2C); take(0, 0);

    // taken branch to last byte (R6, R2 wrap)
    push('h2E); take(1, 0); exp_cs += 2;
    resolve(1'b0, 1'b1, 8'hFF);
    chk("R6 branch taken", int'(imem_hi_addr), 'hFF);
    chk("R2 lo wrap", int'(imem_lo_addr), 0);
    push('hFF); take(0, 0);
    push('h01); take(0, 0);

    // not taken (R6)
    push('h03); take(1, 0); exp_cs += 2;
    resolve(1'b0, 1'b0, 8'h80);
    chk("R6 not taken", int'(imem_hi_addr), 5);
    push('h05); take(0, 0);

    // jump with wrapping offset (R5)
    push('h07); take(1, 0); exp_cs += 2;
    resolve(1'b1, 1'b0, 8'hF0);
    chk("R5 jump wrap", int'(imem_hi_addr), 'hE9);
    push('hE9); take(0, 0);

    // retire counters (R11), stalled meanwhile
    begin
      int codes[13] = '{0, 1, 1, 2, 3, 3, 3, 4, 5, 5, 5, 5, 6};
      foreach (codes[k]) begin
        retire_valid = 1; retire_class = 3'(codes[k]);
        exp_cls[codes[k]]++;
        idle(1);
      end
      retire_class = 3'd7; idle(2);
      retire_valid = 0; retire_class = 0;
    end
    for (int c = 0; c < 7; c++) chk("R11 class count", int'(class_count[c]), exp_cls[c]);
    chk("R3 total data stalls", int'(data_stall_count), exp_ds);
    chk("R4 total ctrl stalls", int'(ctrl_stall_count), exp_cs);
    chk("R9 no done before halt", int'(done), 0);

    // halt and drain (R8, R9, R10)
    push('hEB); take(0, 1);
    back_busy = 1;
    snap = int'(cycle_count);
    idle(2);
    chk("R9 done low while busy", int'(done), 0);
    chk("R10 busy cycles", int'(cycle_count), snap + 2);
    back_busy = 0;
    idle(1);
    chk("R9 done", int'(done), 1);
    snap = int'(cycle_count);
    idle(4);
    chk("R8 no valid after halt", int'(inst_valid), 0);
    chk("R8 pc frozen", int'(imem_hi_addr), 'hED);
    chk("R10 frozen after done", int'(cycle_count), snap);
    chk("R9 done sticky", int'(done), 1);
    chk("R2 queue drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule